// File: doc/BRIEF.md
# Digit-Code Safe Lock Controller

This block decides whether a safe-deposit box is locked or open, based on a four-digit decimal code typed in one digit at a time. Each digit arrives as a BCD nibble with a one-cycle valid strobe. The controller groups the accepted digits into complete entries. It judges an entry only after its last digit has arrived, so no single digit is ever flagged as it comes in.

After reset the box is locked and holds a default code that is set by a parameter. A matching entry opens the box. Opening also wipes the stored code, so the box cannot simply be closed again with the old secret. To lock an open box, the user types a new code and then types it a second time. When the two entries agree, the new code is stored, the box locks, and a one-cycle armed pulse is given. Any wrong result gives a one-cycle error pulse. Keypad scanning, debouncing, display and actuator drive belong to other blocks.

Top module: `safe_lock`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) makes the box locked, loads the stored code from `RESET_CODE`, and holds `err_o` and `armed_o` low. A locked box can only be re-locked through a confirmed new code.
- R2: The stored code is a register that changes while the block runs. After a new code has been confirmed, only that code opens the box. The previous code is rejected with an error.
- R3: When a four-digit entry on a locked box equals the stored code, `is_locked_o` goes low two clock cycles after the strobe of the fourth digit, with no error pulse.
- R4: `err_o` pulses for exactly one cycle, two cycles after the fourth digit's strobe, and never on an earlier digit. After a wrong unlock entry the box stays locked and the next accepted digit starts a new entry.
- R5: Opening the box invalidates the stored code. While the box is open, no single entry locks it, not even the code that just opened it.
- R6: An open box locks only when two consecutive entries are equal. At that point `is_locked_o` rises and `armed_o` pulses high for exactly one cycle, two cycles after the fourth digit of the second entry.
- R7: When the confirming entry differs from the first entry, `err_o` pulses, the box stays open, and the next entry is taken as a new first entry.
- R8: A strobe carrying a digit value above 9 (4'hA to 4'hF) is ignored: it does not count toward the four digits and does not change the entry.
- R9: Digits are matched in entry order. The first digit typed corresponds to bits [15:12] of `RESET_CODE`, and the last digit to bits [3:0].
- R10: A reset in the middle of an entry discards the digits already typed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dig_i | input | 4 | BCD digit value |
| dig_vld_i | input | 1 | One-cycle strobe that qualifies `dig_i` |
| is_locked_o | output | 1 | High while the box is locked |
| err_o | output | 1 | One-cycle pulse when an entry is rejected |
| armed_o | output | 1 | One-cycle pulse when a confirmed code is stored and the box locks |

## Verification
The bench builds the block with four digits and `RESET_CODE` = 16'h7031. This code contains a zero digit and reads differently backwards, so the bench can tell reversed digit order, a stale code and a nibble that reads as zero apart from a correct match. Junk nibbles inserted between real digits show whether ignored strobes can shift the digit count. A reset between two typed digits shows whether a half-finished entry survives.

// File: rtl/safe_lock_pkg.sv
package safe_lock_pkg;

  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef enum logic [1:0] {
    ST_LOCKED  = 2'd0,
    ST_NEW     = 2'd1,
    ST_CONFIRM = 2'd2
  } lock_state_e;

  // A strobed nibble counts as a digit only in the decimal range.
  function automatic logic digit_is_decimal(input logic [DIGIT_W-1:0] d);
    return d <= DIGIT_MAX;
  endfunction

endpackage

// File: rtl/safe_digit_collect.sv
module safe_digit_collect
  import safe_lock_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [DIGIT_W-1:0]               dig_i,
  input  logic                             dig_vld_i,
  output logic [NUM_DIGITS*DIGIT_W-1:0]    entry_o,
  output logic                             done_o
);

  localparam int CODE_W = NUM_DIGITS * DIGIT_W;
  localparam int CNT_W  = $clog2(NUM_DIGITS + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NUM_DIGITS - 1);

  logic [CODE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              accept;
  logic              junk_digit;

  // Earliest digit drifts toward the top nibble as later ones enter.
  function automatic logic [CODE_W-1:0] push_digit(input logic [CODE_W-1:0] code,
                                                   input logic [DIGIT_W-1:0] d);
    return {code[CODE_W-DIGIT_W-1:0], d};
  endfunction

  assign accept     = dig_vld_i && digit_is_decimal(dig_i);
  assign junk_digit = dig_vld_i && !digit_is_decimal(dig_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        shreg_q <= push_digit(shreg_q, dig_i);
        if (cnt_q == LAST_POS) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign entry_o = shreg_q;
  assign done_o  = done_q;

  // R8
  junk_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    junk_digit |=> ($stable(cnt_q) && $stable(shreg_q) && !done_o));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/safe_code_vault.sv
module safe_code_vault
  import safe_lock_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] RESET_CODE = '0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load_i,
  input  logic                           clear_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0]  load_code_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0]  probe_i,
  output logic                           valid_o,
  output logic                           match_o
);

  localparam int CODE_W = NUM_DIGITS * DIGIT_W;

  logic [CODE_W-1:0] code_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= RESET_CODE;
      valid_q <= 1'b1;
    end else if (load_i) begin
      code_q  <= load_code_i;
      valid_q <= 1'b1;
    end else if (clear_i) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign match_o = valid_q && (probe_i == code_q);

  // R5
  clear_invalidates_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !load_i) |=> (!valid_o && !match_o));

  // R2
  load_validates_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> valid_o);

endmodule

// File: rtl/safe_lock.sv
module safe_lock
  import safe_lock_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] RESET_CODE = 16'h1234
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] dig_i,
  input  logic               dig_vld_i,
  output logic               is_locked_o,
  output logic               err_o,
  output logic               armed_o
);

  localparam int CODE_W = NUM_DIGITS * DIGIT_W;

  lock_state_e       state_q;
  logic [CODE_W-1:0] first_q;
  logic              err_q;
  logic              armed_q;

  logic [CODE_W-1:0] entry_code;
  logic              entry_done;
  logic              vault_valid;
  logic              vault_match;

  // Named events for the FSM and the checks.
  logic unlock_ok;
  logic unlock_bad;
  logic first_take;
  logic confirm_ok;
  logic confirm_bad;

  function automatic logic same_code(input logic [CODE_W-1:0] a,
                                     input logic [CODE_W-1:0] b);
    return a == b;
  endfunction

  safe_digit_collect #(
    .NUM_DIGITS (NUM_DIGITS)
  ) u_collect (
    .clk       (clk),
    .rst       (rst),
    .dig_i     (dig_i),
    .dig_vld_i (dig_vld_i),
    .entry_o   (entry_code),
    .done_o    (entry_done)
  );

  safe_code_vault #(
    .NUM_DIGITS (NUM_DIGITS),
    .RESET_CODE (RESET_CODE)
  ) u_vault (
    .clk         (clk),
    .rst         (rst),
    .load_i      (confirm_ok),
    .clear_i     (unlock_ok),
    .load_code_i (entry_code),
    .probe_i     (entry_code),
    .valid_o     (vault_valid),
    .match_o     (vault_match)
  );

  assign unlock_ok   = entry_done && (state_q == ST_LOCKED) && vault_match;
  assign unlock_bad  = entry_done && (state_q == ST_LOCKED) && !vault_match;
  assign first_take  = entry_done && (state_q == ST_NEW);
  assign confirm_ok  = entry_done && (state_q == ST_CONFIRM) && same_code(entry_code, first_q);
  assign confirm_bad = entry_done && (state_q == ST_CONFIRM) && !same_code(entry_code, first_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LOCKED;
      first_q <= '0;
      err_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      err_q   <= unlock_bad || confirm_bad;
      armed_q <= confirm_ok;
      if (unlock_ok)   state_q <= ST_NEW;
      if (first_take) begin
        first_q <= entry_code;
        state_q <= ST_CONFIRM;
      end
      if (confirm_ok)  state_q <= ST_LOCKED;
      if (confirm_bad) state_q <= ST_NEW;
    end
  end

  assign is_locked_o = (state_q == ST_LOCKED);
  assign err_o       = err_q;
  assign armed_o     = armed_q;

  // R6
  armed_locks_chk: assert property (@(posedge clk) disable iff (rst)
    armed_o |-> is_locked_o);

  // R4
  err_armed_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(err_o && armed_o));

  // R3
  open_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(is_locked_o) |-> ($past(entry_done) && !err_o));

  // R5
  open_has_no_code_chk: assert property (@(posedge clk) disable iff (rst)
    !is_locked_o |-> !vault_valid);

  // R1
  lock_needs_confirm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(is_locked_o) |-> armed_o);

  // R7
  confirm_miss_open_chk: assert property (@(posedge clk) disable iff (rst)
    confirm_bad |=> (err_o && !is_locked_o && !armed_o));

  // R4
  unlock_miss_locked_chk: assert property (@(posedge clk) disable iff (rst)
    unlock_bad |=> (err_o && is_locked_o));

endmodule

// File: tb/safe_lock_bench.sv
module safe_lock_bench;
  localparam int NUM_DIGITS = 4;
  localparam logic [15:0] RESET_CODE = 16'h7031;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dig = 4'd0;
  logic       vld = 1'b0;
  logic       is_locked, err, armed;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int    due;
    bit    err;
    bit    armed;
    bit    locked;
    string req;
  } exp_t;
  exp_t exp_q[$];

  // Reference model state
  bit          m_locked;
  bit          m_valid;
  bit          m_confirm;
  logic [15:0] m_code;
  logic [15:0] m_first;
  int          last_drive;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  safe_lock #(.NUM_DIGITS(NUM_DIGITS), .RESET_CODE(RESET_CODE)) u_safe_lock (
    .clk(clk), .rst(rst), .dig_i(dig), .dig_vld_i(vld),
    .is_locked_o(is_locked), .err_o(err), .armed_o(armed)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_locked = 1'b1; m_valid = 1'b1; m_confirm = 1'b0;
    m_code = RESET_CODE; m_first = '0;
  endtask

  task automatic press(input logic [3:0] d);
    @(negedge clk);
    dig = d; vld = 1'b1; last_drive = cyc;
    @(negedge clk);
    vld = 1'b0;
  endtask

  // Predict the outcome of a full entry and queue it for the monitor.
  task automatic push_expect(input logic [15:0] code, input string req);
    exp_t e;
    e.due = last_drive + 2; e.req = req; e.err = 0; e.armed = 0;
    if (m_locked) begin
      if (m_valid && code == m_code) begin
        m_locked = 0; m_valid = 0;
      end else e.err = 1;
    end else if (!m_confirm) begin
      m_first = code; m_confirm = 1;
    end else if (code == m_first) begin
      m_locked = 1; m_valid = 1; m_code = code; m_confirm = 0; e.armed = 1;
    end else begin
      e.err = 1; m_confirm = 0;
    end
    e.locked = m_locked;
    exp_q.push_back(e);
  endtask

  task automatic enter(input logic [15:0] code, input bit junk, input string req);
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (junk) press(4'hA + 4'(i));
      press(code[15-4*i -: 4]);
    end
    push_expect(code, req);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: compare queued results at their due cycle, quiet elsewhere.
  always @(negedge clk) begin
    if (!rst) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(err == e.err, e.req, "err_o", int'(err), int'(e.err));
        chk(armed == e.armed, e.req, "armed_o", int'(armed), int'(e.armed));
        chk(is_locked == e.locked, e.req, "is_locked_o", int'(is_locked), int'(e.locked));
      end else begin
        chk(!err && !armed, "R4", "quiet err/armed", int'({err, armed}), 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(is_locked == 1'b1, "R1", "reset is_locked_o", int'(is_locked), 1);
    chk(!err && !armed, "R1", "reset pulses", int'({err, armed}), 0);

    enter(16'h7032, 0, "R4");        // wrong last digit
    enter(16'h1307, 0, "R9");        // reversed order rejected
    enter(16'h7031, 1, "R8");        // junk nibbles between digits, opens (R3)
    enter(16'h7031, 0, "R5");        // old code only taken as first entry
    enter(16'h4444, 0, "R7");        // confirm mismatch
    enter(16'h2580, 0, "R6");        // first entry
    enter(16'h2580, 0, "R6");        // confirm -> armed, locked
    enter(16'h7031, 0, "R2");        // stale code rejected
    enter(16'h2580, 0, "R3");        // new code opens
    enter(16'h0099, 0, "R6");
    enter(16'h0099, 0, "R6");        // locked with 0099

    // R10: reset between typed digits
    press(4'd0);
    press(4'd0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(is_locked == 1'b1, "R10", "locked after mid reset", int'(is_locked), 1);
    enter(16'h0099, 0, "R1");        // reset restored the default code
    enter(16'h7031, 0, "R10");       // partial digits discarded, opens

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "pending results", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule